// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Grader

The block grades random test patterns against every single stuck-at fault of a small combinational circuit that is built into it. The circuit has two inputs, `a` and `b`. Input `b` is a stem with two branches: one feeds a two-input AND gate together with `a`, and the other feeds an inverter. The AND output and the inverter output feed a two-input OR gate. There are two observed outputs: `y_or`, the OR output, and `y_and`, the AND output. The circuit has seven fault sites, and each site can be stuck at 0 or stuck at 1.

Every net is carried as a word of `LANES` bits. Lane 0 is the fault-free machine. Each other lane is one faulty machine, with the fault forced at its site. One clock cycle evaluates one group of `LANES-1` faults. For each pattern, the controller sweeps all groups that still hold an undetected fault. It merges that pattern's detections into the bitmap once the sweep ends. It then steps a 16-bit LFSR to get the next pattern.

The run stops when every fault is detected or when the pattern limit is reached. The result is a per-fault detected bitmap and a done flag.

Top module: `fsim_engine`

## Requirements
- R1: A synchronous active-high `rst` leaves the block idle with `done` = 0 and `detected` all zero.
- R2: Fault index f = 2*site + v, where v is the stuck value and the site codes are: 0 input a, 1 stem b, 2 branch of b into the AND gate, 3 branch of b into the inverter, 4 AND output, 5 inverter output, 6 OR output. Bit f of `detected` belongs to fault f. A branch fault affects only its own branch.
- R3: Group g places fault g*(LANES-1)+k-1 in lane k, for k = 1 to LANES-1. Lanes past fault 13 carry no fault. The first pattern of a run takes exactly ceil(14/(LANES-1)) cycles, one cycle per group.
- R4: A fault is detected by a pattern when its lane differs from lane 0 at `y_or` or at `y_and`.
- R5: The pattern register q loads `seed` on start, with a zero seed replaced by 1. Input a = q[0] and b = q[1]. Between patterns, q becomes {q[14:0], q[15]^q[13]^q[12]^q[10]}.
- R6: Detections from a pattern enter `detected` only after that pattern's last group. In later patterns, a group whose faults are all detected is skipped and costs no cycle.
- R7: `done` rises after the pattern in which all 14 faults are detected, or after `max_patterns` patterns, whichever comes first. A limit of 0 acts as 1. `done` and `detected` then hold until the next start.
- R8: `start` while a run is in progress has no effect on the result or on the run length.
- R9: `start` while idle begins a new run. On the next cycle `done` is 0 and `detected` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| seed | input | 16 | Initial pattern register value |
| max_patterns | input | CNT_W | Pattern limit, latched at start |
| detected | output | 14 | Per-fault detected bitmap |
| done | output | 1 | Run finished |

## Verification
The bench runs single-pattern grades for all four input combinations against a fault-by-fault serial model.

- A lane mapped to the wrong fault, or a branch fault leaking onto the sibling branch, shows up as a wrong bitmap.
- Full-coverage runs check the cycle count. A design that still visits fully dropped groups, or merges detections mid-pattern, takes a different number of cycles.
- Zero-seed, zero-limit and mid-run start cases catch a stuck LFSR, a run that never ends, or a restart that corrupts the result.

// File: rtl/fsim_pkg.sv
package fsim_pkg;

    localparam int NUM_SITES  = 7;
    localparam int NUM_FAULTS = 2 * NUM_SITES;
    localparam int PAT_W      = 16;

    typedef enum logic [2:0] {
        SITE_A     = 3'd0,
        SITE_B     = 3'd1,
        SITE_B_AND = 3'd2,
        SITE_B_INV = 3'd3,
        SITE_AND   = 3'd4,
        SITE_INV   = 3'd5,
        SITE_OR    = 3'd6
    } site_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef struct packed {
        logic a;
        logic b;
    } pattern_t;

    // Maximal-length 16-bit feedback (taps 16,14,13,11).
    function automatic logic [PAT_W-1:0] pat_step(input logic [PAT_W-1:0] q);
        return {q[PAT_W-2:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

    function automatic pattern_t pat_bits(input logic [PAT_W-1:0] q);
        pattern_t p;
        p.a = q[0];
        p.b = q[1];
        return p;
    endfunction

endpackage

// File: rtl/fsim_lfsr.sv
module fsim_lfsr
    import fsim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PAT_W-1:0] seed,
    input  logic             step,
    output logic [PAT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= PAT_W'(1);
        else if (load)
            q <= (seed == '0) ? PAT_W'(1) : seed;
        else if (step)
            q <= pat_step(q);
    end
endmodule

// File: rtl/fsim_inject.sv
module fsim_inject
    import fsim_pkg::*;
#(
    parameter int LANES = 4,
    parameter int GRP_W = 3
) (
    input  logic [GRP_W-1:0]                  grp,
    input  logic [NUM_FAULTS-1:0]             dropped,
    output logic [NUM_SITES-1:0][LANES-1:0]   force0,
    output logic [NUM_SITES-1:0][LANES-1:0]   force1,
    output logic [LANES-1:0]                  valid
);
    localparam int PER    = LANES - 1;
    localparam int GROUPS = (NUM_FAULTS + PER - 1) / PER;
    localparam int SLOTS  = GROUPS * PER;
    localparam int IDX_W  = $clog2(SLOTS + 1);

    logic [SLOTS-1:0] dropped_pad;
    assign dropped_pad = {{(SLOTS - NUM_FAULTS){1'b1}}, dropped};

    assign valid[0] = 1'b0;
    for (genvar s = 0; s < NUM_SITES; s++) begin : g_lane0
        assign force0[s][0] = 1'b0;
        assign force1[s][0] = 1'b0;
    end

    for (genvar k = 1; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0] fidx;
        logic             live;
        assign fidx = IDX_W'(grp) * IDX_W'(PER) + IDX_W'(k - 1);
        assign live = !dropped_pad[fidx];
        assign valid[k] = live;
        for (genvar s = 0; s < NUM_SITES; s++) begin : g_site
            logic here;
            assign here = live && ((fidx >> 1) == IDX_W'(s));
            assign force0[s][k] = here && !fidx[0];
            assign force1[s][k] = here &&  fidx[0];
        end
    end
endmodule

// File: rtl/fsim_netlist.sv
module fsim_netlist
    import fsim_pkg::*;
#(
    parameter int LANES = 4
) (
    input  pattern_t                        pat,
    input  logic [NUM_SITES-1:0][LANES-1:0] force0,
    input  logic [NUM_SITES-1:0][LANES-1:0] force1,
    output logic [LANES-1:0]                y_or,
    output logic [LANES-1:0]                y_and
);
    function automatic logic [LANES-1:0] pin(input logic [LANES-1:0] w,
                                             input logic [LANES-1:0] f0,
                                             input logic [LANES-1:0] f1);
        return (w & ~f0) | f1;
    endfunction

    logic [LANES-1:0] w_a, w_b, w_b_and, w_b_inv, w_and, w_inv;

    always_comb begin
        w_a     = pin({LANES{pat.a}}, force0[SITE_A], force1[SITE_A]);
        w_b     = pin({LANES{pat.b}}, force0[SITE_B], force1[SITE_B]);
        w_b_and = pin(w_b, force0[SITE_B_AND], force1[SITE_B_AND]);
        w_b_inv = pin(w_b, force0[SITE_B_INV], force1[SITE_B_INV]);
        w_and   = pin(w_a & w_b_and, force0[SITE_AND], force1[SITE_AND]);
        w_inv   = pin(~w_b_inv, force0[SITE_INV], force1[SITE_INV]);
        y_or    = pin(w_and | w_inv, force0[SITE_OR], force1[SITE_OR]);
        y_and   = w_and;
    end
endmodule

// File: rtl/fsim_detect.sv
module fsim_detect
    import fsim_pkg::*;
#(
    parameter int LANES = 4,
    parameter int GRP_W = 3
) (
    input  logic [GRP_W-1:0]      grp,
    input  logic [LANES-1:0]      valid,
    input  logic [LANES-1:0]      y_or,
    input  logic [LANES-1:0]      y_and,
    output logic [NUM_FAULTS-1:0] hits
);
    localparam int PER = LANES - 1;

    logic [LANES-1:0] lane_hit;
    assign lane_hit = ((y_or  ^ {LANES{y_or[0]}}) |
                       (y_and ^ {LANES{y_and[0]}})) & valid;

    for (genvar f = 0; f < NUM_FAULTS; f++) begin : g_fault
        localparam int G = f / PER;
        localparam int L = f % PER + 1;
        assign hits[f] = (grp == GRP_W'(G)) && lane_hit[L];
    end
endmodule

// File: rtl/fsim_engine.sv
module fsim_engine
    import fsim_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [15:0]           seed,
    input  logic [CNT_W-1:0]      max_patterns,
    output logic [NUM_FAULTS-1:0] detected,
    output logic                  done
);
    localparam int PER    = LANES - 1;
    localparam int GROUPS = (NUM_FAULTS + PER - 1) / PER;
    localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    function automatic logic [NUM_FAULTS-1:0] gmask(input int g);
        logic [NUM_FAULTS-1:0] m;
        for (int f = 0; f < NUM_FAULTS; f++) m[f] = ((f / PER) == g);
        return m;
    endfunction

    state_e                 state;
    logic [GRP_W-1:0]       grp;
    logic [NUM_FAULTS-1:0]  det, pend, hits, det_new;
    logic [CNT_W-1:0]       cnt, limit, limit_eff, cnt_next;
    logic [PAT_W-1:0]       lfsr_q;
    logic [GROUPS-1:0]      live_cur, live_new;
    logic [GRP_W-1:0]       nxt_grp, first_new;
    logic                   has_next, pat_end, finish, load;

    logic [NUM_SITES-1:0][LANES-1:0] force0, force1;
    logic [LANES-1:0]                valid, y_or, y_and;

    fsim_lfsr i_lfsr (
        .clk (clk), .rst (rst), .load (load), .seed (seed),
        .step (pat_end && !finish), .q (lfsr_q)
    );

    fsim_inject #(.LANES(LANES), .GRP_W(GRP_W)) i_inject (
        .grp (grp), .dropped (det),
        .force0 (force0), .force1 (force1), .valid (valid)
    );

    fsim_netlist #(.LANES(LANES)) i_netlist (
        .pat (pat_bits(lfsr_q)), .force0 (force0), .force1 (force1),
        .y_or (y_or), .y_and (y_and)
    );

    fsim_detect #(.LANES(LANES), .GRP_W(GRP_W)) i_detect (
        .grp (grp), .valid (valid), .y_or (y_or), .y_and (y_and), .hits (hits)
    );

    assign det_new = det | pend | hits;

    for (genvar g = 0; g < GROUPS; g++) begin : g_live
        assign live_cur[g] = |(gmask(g) & ~det);
        assign live_new[g] = |(gmask(g) & ~det_new);
    end

    always_comb begin
        nxt_grp   = '0;
        has_next  = 1'b0;
        first_new = '0;
        for (int g = GROUPS - 1; g >= 0; g--) begin
            if (GRP_W'(g) > grp && live_cur[g]) begin
                nxt_grp  = GRP_W'(g);
                has_next = 1'b1;
            end
            if (live_new[g]) first_new = GRP_W'(g);
        end
    end

    assign limit_eff = (limit == '0) ? CNT_W'(1) : limit;
    assign cnt_next  = cnt + CNT_W'(1);
    assign pat_end   = (state == ST_RUN) && !has_next;
    assign finish    = pat_end && ((&det_new) || (cnt_next >= limit_eff));
    assign load      = start && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            grp   <= '0;
            det   <= '0;
            pend  <= '0;
            cnt   <= '0;
            limit <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    grp   <= '0;
                    det   <= '0;
                    pend  <= '0;
                    cnt   <= '0;
                    limit <= max_patterns;
                    done  <= 1'b0;
                end
                ST_RUN: if (pat_end) begin
                    det  <= det_new;
                    pend <= '0;
                    cnt  <= cnt_next;
                    if (finish) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        grp <= first_new;
                    end
                end else begin
                    pend <= pend | hits;
                    grp  <= nxt_grp;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign detected = det;

    // Dropped faults never occupy a lane again (R6).
    assert_drop_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> ((hits & det) == '0));

    // Bitmap only grows during a run (R6).
    assert_bitmap_grows_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> ((det & $past(det)) == $past(det)));

    // Group index stays inside the fault table (R3).
    assert_grp_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (grp < GRP_W'(GROUPS)));

    // Pattern count never reaches the limit while running (R7).
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (cnt < limit_eff));

    // Result holds after completion (R7).
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(det)));

    // Pattern register never locks up at zero (R5).
    assert_seed_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (lfsr_q != '0));

    // A start pulse mid-run does not leave the run (R8).
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && start && !pat_end) |=> (state == ST_RUN));
endmodule

// File: tb/test_fsim_engine.sv
module test_fsim_engine;
    localparam int LANES  = 4;
    localparam int CNT_W  = 16;
    localparam int NF     = 14;
    localparam int PER    = LANES - 1;
    localparam int GROUPS = (NF + PER - 1) / PER;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [15:0]      seed = '0;
    logic [CNT_W-1:0] max_patterns = '0;
    logic [NF-1:0]    detected;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    fsim_engine #(.LANES(LANES), .CNT_W(CNT_W)) i_fsim_engine (
        .clk (clk), .rst (rst), .start (start), .seed (seed),
        .max_patterns (max_patterns), .detected (detected), .done (done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit fz(bit v, int site, int f);
        return (f >= 0 && f / 2 == site) ? bit'(f % 2) : v;
    endfunction

    // Serial single-fault evaluation: returns {y_and, y_or}.
    function automatic logic [1:0] eval1(bit a, bit b, int f);
        bit na, nb, ba, bi, gand, ginv, gor;
        na   = fz(a, 0, f);
        nb   = fz(b, 1, f);
        ba   = fz(nb, 2, f);
        bi   = fz(nb, 3, f);
        gand = fz(na & ba, 4, f);
        ginv = fz(!bi, 5, f);
        gor  = fz(gand | ginv, 6, f);
        return {gand, gor};
    endfunction

    function automatic logic [15:0] nxt(logic [15:0] q);
        return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    endfunction

    task automatic model(input logic [15:0] sd, input int maxp,
                         output logic [NF-1:0] det, output int cyc);
        logic [15:0]   q;
        logic [NF-1:0] pend;
        int            lim, cnt;
        q   = (sd == 0) ? 16'd1 : sd;
        det = '0;
        cyc = 0;
        cnt = 0;
        lim = (maxp == 0) ? 1 : maxp;
        forever begin
            for (int g = 0; g < GROUPS; g++) begin
                bit live = 0;
                for (int f = g * PER; f < (g + 1) * PER && f < NF; f++)
                    if (!det[f]) live = 1;
                if (live) cyc++;
            end
            pend = '0;
            for (int f = 0; f < NF; f++)
                if (!det[f] && eval1(q[0], q[1], f) != eval1(q[0], q[1], -1))
                    pend[f] = 1'b1;
            det |= pend;
            cnt++;
            if (&det || cnt >= lim) break;
            q = nxt(q);
        end
    endtask

    task automatic run_case(input string req, input logic [15:0] sd,
                            input int maxp, input bit poke);
        logic [NF-1:0] exp_det;
        int            exp_cyc, cyc;
        model(sd, maxp, exp_det, exp_cyc);
        @(negedge clk);
        seed = sd;
        max_patterns = CNT_W'(maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({req, " R9 cleared after start"}, {31'd0, done}, 32'd0);
        chk({req, " R9 bitmap cleared"}, 32'(detected), 32'd0);
        cyc = 0;
        while (!done && cyc < 5000) begin
            start = (poke && (cyc == 2 || cyc == 3));
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk({req, " done"}, {31'd0, done}, 32'd1);
        chk({req, " cycles"}, 32'(cyc), 32'(exp_cyc));
        chk({req, " bitmap"}, 32'(detected), 32'(exp_det));
    endtask

    task automatic t_reset();
        chk("R1 done after reset", {31'd0, done}, 32'd0);
        chk("R1 bitmap after reset", 32'(detected), 32'd0);
    endtask

    task automatic t_single_patterns();
        // seeds 1..4 give (a,b) = (1,0), (0,1), (1,1), (0,0)
        for (int s = 1; s <= 4; s++) begin
            run_case("R2 R3 R4 single pattern", 16'(s), 1, 0);
        end
    endtask

    task automatic t_full_cover();
        run_case("R6 R7 full coverage", 16'hACE1, 200, 0);
        chk("R7 all faults detected", 32'(detected), 32'h3FFF);
        run_case("R5 R6 full coverage second seed", 16'h1234, 200, 0);
    endtask

    task automatic t_zero_seed();
        logic [NF-1:0] d1;
        int            c1;
        model(16'd1, 6, d1, c1);
        run_case("R5 zero seed", 16'd0, 6, 0);
        chk("R5 zero seed equals seed one", 32'(detected), 32'(d1));
    endtask

    task automatic t_limits();
        run_case("R7 limit two", 16'h0005, 2, 0);
        run_case("R7 limit zero acts as one", 16'h0003, 0, 0);
    endtask

    task automatic t_start_mid_run();
        run_case("R8 start during run", 16'hBEEF, 200, 1);
    endtask

    task automatic t_hold();
        logic [NF-1:0] snap;
        snap = detected;
        repeat (6) @(negedge clk);
        chk("R7 done held", {31'd0, done}, 32'd1);
        chk("R7 bitmap held", 32'(detected), 32'(snap));
    endtask

    initial begin
        #(2_000_000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_patterns();
        t_full_cover();
        t_hold();
        t_zero_seed();
        t_limits();
        t_start_mid_run();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule